// File: doc/BRIEF.md
# Serial EEPROM Access Controller

This block lets a host reach a byte-wide external EEPROM through a few registers. The host can ask for one byte to be read into a data register or for one byte to be written from it. The host can also start a burst that walks the EEPROM, decodes address/data records from it and stores each data word into on-chip memory through a 24-bit write port. Request bits clear themselves when the work is done, so the host sets a bit and then polls it back to zero.

The EEPROM side uses a plain request/acknowledge exchange: the controller holds an address, a direction and write data until the device pulses an acknowledge, which carries the read byte. A burst starts at EEPROM address 0 if nothing has been accessed since reset. Otherwise it starts at the address after the most recent access, so a burst can continue from where a single access left off.

Top module: `eeprom_xfer_ctl`

## Requirements
- R1: After reset every host register reads 0, `ee_req` is 0 and `mem_we` is 0.
- R2: Writing a 1 to bit 1 of the control register (offset 0) requests a single-byte read from the EEPROM address held in the address register. The bit reads 1 until the read completes, then reads 0, and the data register holds the byte. Writing 0 to a control bit has no effect.
- R3: Writing a 1 to bit 0 of the control register requests a single-byte write of the data register's low byte to the EEPROM address held in the address register (`ee_we`=1). The bit clears itself when the write completes.
- R4: The data register (offset 2) stores 8 bits. Its bits [31:8] always read 0.
- R5: Writing a 1 to bit 0 of the burst start register (offset 4) starts a burst. The bit reads 1 while the burst runs and clears itself when the burst ends.
- R6: A burst begins at EEPROM address 0 if no access has happened since reset. Otherwise it begins at the address after the last EEPROM byte accessed, wrapping from 0xFFFF to 0x0000.
- R7: Burst content is a series of 6-byte records: a 16-bit record address (high byte first) followed by a 32-bit word (first byte most significant). Each complete record causes one `mem_we` pulse carrying that word. A record address of 0xFFFF ends the burst and causes no memory write.
- R8: A burst memory address is {base register bits [8:0], record address bits [14:0]}. Record address bit 15 is dropped. The base register is at offset 3.
- R9: Only one operation runs at a time. Requests that arrive while the controller is busy wait. When several are pending in the idle state, the order is read, then write, then burst.
- R10: `ee_req` stays high, with `ee_addr`, `ee_we` and `ee_wdata` unchanged, until `ee_ack` is seen. It is low in the cycle after the acknowledge.
- R11: If a read completes in the same cycle as a host write to the data register, the data register takes the EEPROM byte.
- R12: The register offsets are control 0, address 1 (16 bits), data 2, base 3 (9 bits) and burst start 4. Offsets 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register offset for write and read |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr` |
| ee_req | output | 1 | EEPROM byte request |
| ee_we | output | 1 | Request direction, 1 = write |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | Device acknowledge pulse |
| ee_rdata | input | 8 | Read byte, valid with `ee_ack` |
| mem_we | output | 1 | Internal memory write pulse |
| mem_addr | output | 24 | Internal memory write address |
| mem_wdata | output | 32 | Internal memory write word |

## Verification
The data register has two writers: the host port and the completion of an EEPROM read. These two can collide on the same clock edge. The bench watches for the device acknowledge of a pending single read and, in that same cycle, drives a host write of a different value to the data register. It then judges the outcome by reading the register back and expecting the EEPROM byte. A second overlap, a burst request written while a single read is still in flight, is judged from the order of device accesses that the bench's device model logs.

// File: rtl/eectl_pkg.sv
package eectl_pkg;

    // Host register offsets
    localparam int unsigned OFS_CTRL  = 0;
    localparam int unsigned OFS_ADDR  = 1;
    localparam int unsigned OFS_DATA  = 2;
    localparam int unsigned OFS_BASE  = 3;
    localparam int unsigned OFS_START = 4;

    // Control register bit positions
    localparam int unsigned CTRL_WR_BIT = 0;
    localparam int unsigned CTRL_RD_BIT = 1;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SINGLE = 2'd1,
        SQ_BURST  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/eectl_hostregs.sv
module eectl_hostregs
    import eectl_pkg::*;
#(
    parameter int unsigned HW  = 32,
    parameter int unsigned RAW = 3,
    parameter int unsigned EAW = 16,
    parameter int unsigned BW  = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [RAW-1:0] addr,
    input  logic [HW-1:0]  wdata,
    input  logic           rd_done,
    input  logic           wr_done,
    input  logic           burst_done,
    input  logic           cap_en,
    input  logic [7:0]     cap_byte,
    output logic [HW-1:0]  rdata,
    output logic           rd_req,
    output logic           wr_req,
    output logic           burst_req,
    output logic [EAW-1:0] ee_addr_reg,
    output logic [7:0]     data_byte,
    output logic [BW-1:0]  base_reg
);

    typedef struct packed {
        logic           rd;
        logic           wr;
        logic           go;
        logic [EAW-1:0] adr;
        logic [7:0]     dat;
        logic [BW-1:0]  base;
    } regs_t;

    regs_t q, d;

    logic unused_hi;
    assign unused_hi = ^wdata[HW-1:EAW];

    always_comb begin
        d = q;
        if (wr_en) begin
            case (addr)
                RAW'(OFS_CTRL): begin
                    d.rd = q.rd | wdata[CTRL_RD_BIT];
                    d.wr = q.wr | wdata[CTRL_WR_BIT];
                end
                RAW'(OFS_ADDR):  d.adr  = wdata[EAW-1:0];
                RAW'(OFS_DATA):  d.dat  = wdata[7:0];
                RAW'(OFS_BASE):  d.base = wdata[BW-1:0];
                RAW'(OFS_START): d.go   = q.go | wdata[0];
                default: ;
            endcase
        end
        // completion clears the request bit, even one re-set in the same cycle
        if (rd_done)    d.rd = 1'b0;
        if (wr_done)    d.wr = 1'b0;
        if (burst_done) d.go = 1'b0;
        // a returning read byte takes precedence over a host data write
        if (cap_en)     d.dat = cap_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RAW'(OFS_CTRL): begin
                rdata[CTRL_RD_BIT] = q.rd;
                rdata[CTRL_WR_BIT] = q.wr;
            end
            RAW'(OFS_ADDR):  rdata[EAW-1:0] = q.adr;
            RAW'(OFS_DATA):  rdata[7:0]     = q.dat;
            RAW'(OFS_BASE):  rdata[BW-1:0]  = q.base;
            RAW'(OFS_START): rdata[0]       = q.go;
            default: ;
        endcase
    end

    assign rd_req      = q.rd;
    assign wr_req      = q.wr;
    assign burst_req   = q.go;
    assign ee_addr_reg = q.adr;
    assign data_byte   = q.dat;
    assign base_reg    = q.base;

    AST_RD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.rd) |-> $past(rd_done)); // R2
    AST_WR_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.wr) |-> $past(wr_done)); // R3
    AST_GO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.go) |-> $past(burst_done)); // R5
    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> data_byte == $past(cap_byte)); // R11

endmodule

// File: rtl/eectl_cursor.sv
module eectl_cursor #(
    parameter int unsigned EAW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           touch,
    input  logic [EAW-1:0] touch_addr,
    output logic [EAW-1:0] origin
);

    typedef struct packed {
        logic [EAW-1:0] last;
        logic           seen;
    } cur_t;

    cur_t q, d;

    always_comb begin
        d = q;
        if (touch) begin
            d.last = touch_addr;
            d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign origin = q.seen ? q.last + 1'b1 : '0;

    AST_ORIGIN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> origin == $past(touch_addr) + 1'b1); // R6

endmodule

// File: rtl/eectl_seq.sv
module eectl_seq
    import eectl_pkg::*;
#(
    parameter int unsigned EAW = 16,
    parameter int unsigned MAW = 24,
    parameter int unsigned BW  = 9,
    parameter int unsigned WB  = 4,
    parameter int unsigned HB  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_req,
    input  logic           wr_req,
    input  logic           burst_req,
    input  logic [EAW-1:0] reg_addr,
    input  logic [7:0]     reg_byte,
    input  logic [BW-1:0]  base,
    input  logic [EAW-1:0] origin,
    input  logic           ee_ack,
    input  logic [7:0]     ee_rdata,
    output logic           ee_req,
    output logic           ee_we,
    output logic [EAW-1:0] ee_addr,
    output logic [7:0]     ee_wdata,
    output logic           mem_we,
    output logic [MAW-1:0] mem_addr,
    output logic [8*WB-1:0] mem_wdata,
    output logic           rd_done,
    output logic           wr_done,
    output logic           burst_done,
    output logic           cap_en,
    output logic [7:0]     cap_byte,
    output logic           touch,
    output logic [EAW-1:0] touch_addr
);

    localparam int unsigned LOW_W  = MAW - BW;
    localparam int unsigned WORD_W = 8 * WB;
    localparam int unsigned REC_B  = HB + WB;
    localparam int unsigned IDX_W  = $clog2(REC_B + 1);

    typedef struct packed {
        seq_state_e     st;
        logic           req;
        logic           we;
        logic [EAW-1:0] addr;
        logic [7:0]     wdata;
        logic [EAW-1:0] ptr;
        logic [IDX_W-1:0] idx;
        logic [EAW-1:0] rec;
        logic [WORD_W-1:0] word;
        logic           mem_we;
        logic [MAW-1:0] mem_addr;
        logic [WORD_W-1:0] mem_wdata;
    } seq_t;

    seq_t q, d;
    logic [EAW-1:0]    nxt_rec;
    logic [WORD_W-1:0] nxt_word;

    always_comb begin
        d          = q;
        d.mem_we   = 1'b0;
        rd_done    = 1'b0;
        wr_done    = 1'b0;
        burst_done = 1'b0;
        cap_en     = 1'b0;
        touch      = 1'b0;
        nxt_rec    = {q.rec[EAW-9:0], ee_rdata};
        nxt_word   = {q.word[WORD_W-9:0], ee_rdata};
        unique case (q.st)
            SQ_IDLE: begin
                if (rd_req) begin
                    d.st   = SQ_SINGLE;
                    d.req  = 1'b1;
                    d.we   = 1'b0;
                    d.addr = reg_addr;
                end else if (wr_req) begin
                    d.st    = SQ_SINGLE;
                    d.req   = 1'b1;
                    d.we    = 1'b1;
                    d.addr  = reg_addr;
                    d.wdata = reg_byte;
                end else if (burst_req) begin
                    d.st  = SQ_BURST;
                    d.req = 1'b0;
                    d.we  = 1'b0;
                    d.ptr = origin;
                    d.idx = '0;
                end
            end
            SQ_SINGLE: begin
                if (q.req && ee_ack) begin
                    d.req = 1'b0;
                    d.st  = SQ_IDLE;
                    touch = 1'b1;
                    if (q.we) begin
                        wr_done = 1'b1;
                    end else begin
                        rd_done = 1'b1;
                        cap_en  = 1'b1;
                    end
                end
            end
            SQ_BURST: begin
                if (!q.req) begin
                    d.req  = 1'b1;
                    d.we   = 1'b0;
                    d.addr = q.ptr;
                end else if (ee_ack) begin
                    touch = 1'b1;
                    d.req = 1'b0;
                    d.ptr = q.ptr + 1'b1;
                    if (q.idx < IDX_W'(HB)) d.rec  = nxt_rec;
                    else                    d.word = nxt_word;
                    if ((q.idx == IDX_W'(HB - 1)) && (&nxt_rec)) begin
                        d.st       = SQ_IDLE;
                        d.idx      = '0;
                        burst_done = 1'b1;
                    end else if (q.idx == IDX_W'(REC_B - 1)) begin
                        d.idx       = '0;
                        d.mem_we    = 1'b1;
                        d.mem_addr  = {base, q.rec[LOW_W-1:0]};
                        d.mem_wdata = nxt_word;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            default: begin
                d.st  = SQ_IDLE;
                d.req = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ee_req     = q.req;
    assign ee_we      = q.we;
    assign ee_addr    = q.addr;
    assign ee_wdata   = q.wdata;
    assign mem_we     = q.mem_we;
    assign mem_addr   = q.mem_addr;
    assign mem_wdata  = q.mem_wdata;
    assign cap_byte   = ee_rdata;
    assign touch_addr = q.addr;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && !ee_ack) |=> ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata)); // R10
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && ee_ack) |=> !ee_req); // R10
    AST_MEM_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[MAW-1:LOW_W] == $past(base)); // R8
    AST_SINGLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_SINGLE) |-> !mem_we); // R9

endmodule

// File: rtl/eeprom_xfer_ctl.sv
module eeprom_xfer_ctl #(
    parameter int unsigned HOST_W     = 32,
    parameter int unsigned REG_AW     = 3,
    parameter int unsigned EE_AW      = 16,
    parameter int unsigned MEM_AW     = 24,
    parameter int unsigned BASE_W     = 9,
    parameter int unsigned WORD_BYTES = 4,
    parameter int unsigned HDR_BYTES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [HOST_W-1:0]       reg_wdata,
    output logic [HOST_W-1:0]       reg_rdata,
    output logic                    ee_req,
    output logic                    ee_we,
    output logic [EE_AW-1:0]        ee_addr,
    output logic [7:0]              ee_wdata,
    input  logic                    ee_ack,
    input  logic [7:0]              ee_rdata,
    output logic                    mem_we,
    output logic [MEM_AW-1:0]       mem_addr,
    output logic [8*WORD_BYTES-1:0] mem_wdata
);

    logic             rd_req, wr_req, burst_req;
    logic             rd_done, wr_done, burst_done;
    logic             cap_en, touch;
    logic [7:0]       cap_byte, data_byte;
    logic [EE_AW-1:0] addr_reg, origin, touch_addr;
    logic [BASE_W-1:0] base_reg;

    eectl_hostregs #(
        .HW (HOST_W),
        .RAW(REG_AW),
        .EAW(EE_AW),
        .BW (BASE_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rd_done    (rd_done),
        .wr_done    (wr_done),
        .burst_done (burst_done),
        .cap_en     (cap_en),
        .cap_byte   (cap_byte),
        .rdata      (reg_rdata),
        .rd_req     (rd_req),
        .wr_req     (wr_req),
        .burst_req  (burst_req),
        .ee_addr_reg(addr_reg),
        .data_byte  (data_byte),
        .base_reg   (base_reg)
    );

    eectl_cursor #(
        .EAW(EE_AW)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_addr(touch_addr),
        .origin    (origin)
    );

    eectl_seq #(
        .EAW(EE_AW),
        .MAW(MEM_AW),
        .BW (BASE_W),
        .WB (WORD_BYTES),
        .HB (HDR_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .burst_req (burst_req),
        .reg_addr  (addr_reg),
        .reg_byte  (data_byte),
        .base      (base_reg),
        .origin    (origin),
        .ee_ack    (ee_ack),
        .ee_rdata  (ee_rdata),
        .ee_req    (ee_req),
        .ee_we     (ee_we),
        .ee_addr   (ee_addr),
        .ee_wdata  (ee_wdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rd_done   (rd_done),
        .wr_done   (wr_done),
        .burst_done(burst_done),
        .cap_en    (cap_en),
        .cap_byte  (cap_byte),
        .touch     (touch),
        .touch_addr(touch_addr)
    );

    AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == REG_AW'(2)) |-> reg_rdata[HOST_W-1:8] == '0); // R4

endmodule

// File: tb/eeprom_xfer_ctl_tb.sv
module eeprom_xfer_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ee_req, ee_we;
    logic [15:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic        ee_ack = 1'b0;
    logic [7:0]  ee_rdata = '0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;

    always #4 clk = ~clk;

    eeprom_xfer_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ee_req(ee_req),
        .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_ack(ee_ack),
        .ee_rdata(ee_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    int checks = 0;
    int fails  = 0;
    int lat    = 1;
    int cyc    = 0;
    bit mon_en = 1'b0;

    logic [7:0]  rom [int];
    int          log_addr [$];
    bit          log_we [$];
    logic [23:0] exp_ma [$];
    logic [31:0] exp_md [$];

    function automatic logic [7:0] rom_byte(int a);
        if (rom.exists(a)) return rom[a];
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // device model: acknowledge after lat cycles of request
    int cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            ee_ack <= 1'b0;
            cnt = 0;
        end else if (ee_ack) begin
            ee_ack <= 1'b0;
            cnt = 0;
        end else if (ee_req) begin
            cnt++;
            if (cnt >= lat) begin
                cnt = 0;
                ee_ack <= 1'b1;
                if (ee_we) rom[int'(ee_addr)] = ee_wdata;
                else       ee_rdata <= rom_byte(int'(ee_addr));
                log_addr.push_back(int'(ee_addr));
                log_we.push_back(ee_we);
            end
        end else begin
            cnt = 0;
        end
    end

    // per-clock reference comparison of the handshake and memory port
    logic        p_req = 1'b0, p_we = 1'b0;
    logic [15:0] p_addr = '0;
    logic [7:0]  p_wd = '0;
    always begin
        @(posedge clk);
        #2;
        if (mon_en) begin
            if (p_req && !ee_ack) begin
                chk("R10 req held", {ee_req, ee_we, ee_addr, ee_wdata},
                    {1'b1, p_we, p_addr, p_wd});
            end
            if (p_req && ee_ack) chk("R10 req drop", 32'(ee_req), 32'd0);
            if (mem_we) begin
                if (exp_ma.size() == 0) begin
                    chk("R7 unexpected mem write", 32'd1, 32'd0);
                end else begin
                    chk("R8 mem addr", 32'(mem_addr), 32'(exp_ma.pop_front()));
                    chk("R7 mem word", mem_wdata, exp_md.pop_front());
                end
            end
        end
        p_req  = ee_req;
        p_we   = ee_we;
        p_addr = ee_addr;
        p_wd   = ee_wdata;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    task automatic wr_reg(logic [2:0] a, logic [31:0] v);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [31:0] v);
        @(negedge clk); #1;
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_zero(logic [2:0] a, string req);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd_reg(a, v);
            if (v == 0) return;
        end
        chk({req, " timeout"}, v, 32'd0);
    endtask

    function automatic void add_rec(int at, logic [15:0] ra, logic [31:0] w);
        rom[at]   = ra[15:8];
        rom[at+1] = ra[7:0];
        for (int k = 0; k < 4; k++) rom[at+2+k] = w[31-8*k -: 8];
    endfunction

    initial begin
        logic [31:0] v;
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd_reg(3'(a), v);
            chk("R1 reg reset", v, 32'd0);
        end
        chk("R1 ee_req reset", 32'(ee_req), 32'd0);
        chk("R1 mem_we reset", 32'(mem_we), 32'd0);

        // R5/R6/R7/R8 burst right after reset begins at 0
        add_rec(0, 16'h8123, 32'hDEADBEEF);
        add_rec(6, 16'h0010, 32'h01020304);
        rom[12] = 8'hFF; rom[13] = 8'hFF;
        exp_ma.push_back({9'h1A5, 15'h0123}); exp_md.push_back(32'hDEADBEEF);
        exp_ma.push_back({9'h1A5, 15'h0010}); exp_md.push_back(32'h01020304);
        wr_reg(3, 32'h0000_01A5);
        wr_reg(4, 32'h1);
        rd_reg(4, v);
        chk("R5 start busy", v, 32'd1);
        wait_zero(4, "R5");
        chk("R6 origin after reset", 32'(log_addr[0]), 32'd0);
        chk("R7 byte count", 32'(log_addr.size()), 32'd14);
        chk("R7 all records stored", 32'(exp_ma.size()), 32'd0);
        log_addr.delete(); log_we.delete();

        // R2/R4 single read
        rom[32'h200] = 8'h9C;
        wr_reg(1, 32'h0200);
        wr_reg(0, 32'h2);
        rd_reg(0, v);
        chk("R2 read bit busy", v, 32'd2);
        wait_zero(0, "R2");
        rd_reg(2, v);
        chk("R2 R4 read data", v, 32'h9C);
        chk("R2 read addr", 32'(log_addr[0]), 32'h200);
        log_addr.delete(); log_we.delete();

        // R3/R4 single write
        wr_reg(2, 32'hFFFF_FFA7);
        rd_reg(2, v);
        chk("R4 upper zero", v, 32'hA7);
        wr_reg(1, 32'h0300);
        lat = 2;
        wr_reg(0, 32'h1);
        wait_zero(0, "R3");
        chk("R3 rom written", 32'(rom_byte(32'h300)), 32'hA7);
        chk("R3 write direction", 32'(log_we[0]), 32'd1);
        log_addr.delete(); log_we.delete();

        // R6 burst continues after last access
        add_rec(32'h301, 16'h7FFE, 32'h55AA1234);
        rom[32'h307] = 8'hFF; rom[32'h308] = 8'hFF;
        exp_ma.push_back({9'h0FF, 15'h7FFE}); exp_md.push_back(32'h55AA1234);
        lat = 3;
        wr_reg(3, 32'h0FF);
        wr_reg(4, 32'h1);
        wait_zero(4, "R6");
        chk("R6 resume origin", 32'(log_addr[0]), 32'h301);
        chk("R8 record stored", 32'(exp_ma.size()), 32'd0);
        log_addr.delete(); log_we.delete();

        // R9 priority and hold-off
        lat = 2;
        rom[32'h401] = 8'hFF; rom[32'h402] = 8'hFF;
        wr_reg(1, 32'h0400);
        wr_reg(0, 32'h3);
        wr_reg(4, 32'h1);
        wait_zero(0, "R9");
        wait_zero(4, "R9");
        chk("R9 op count", 32'(log_addr.size()), 32'd4);
        chk("R9 read first", {log_addr[0][15:0], 15'd0, log_we[0]}, {16'h0400, 16'h0});
        chk("R9 write second", {log_addr[1][15:0], 15'd0, log_we[1]}, {16'h0400, 16'h1});
        chk("R9 burst third", 32'(log_addr[2]), 32'h401);
        log_addr.delete(); log_we.delete();

        // R11 read completion collides with host data write
        rom[32'h500] = 8'hC3;
        wr_reg(1, 32'h0500);
        wr_reg(0, 32'h2);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk); #1;
            if (ee_ack) break;
        end
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h33;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        wait_zero(0, "R11");
        rd_reg(2, v);
        chk("R11 read byte wins", v, 32'hC3);
        log_addr.delete(); log_we.delete();

        // R2 writing zeros has no effect
        n0 = log_addr.size();
        wr_reg(0, 32'h0);
        wr_reg(4, 32'h0);
        repeat (20) @(negedge clk);
        chk("R2 zero write no access", 32'(log_addr.size()), 32'(n0));
        rd_reg(0, v);
        chk("R2 zero write ctrl", v, 32'd0);

        // R6 wrap from 0xFFFF
        wr_reg(1, 32'hFFFF);
        wr_reg(0, 32'h2);
        wait_zero(0, "R6");
        rom[0] = 8'hFF; rom[1] = 8'hFF;
        wr_reg(4, 32'h1);
        wait_zero(4, "R6");
        chk("R6 wrap origin", 32'(log_addr[1]), 32'h0);

        // R12 map
        rd_reg(1, v);
        chk("R12 addr reg", v, 32'hFFFF);
        for (int a = 5; a < 8; a++) begin
            rd_reg(3'(a), v);
            chk("R12 unused offset", v, 32'd0);
        end

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule